// File: doc/BRIEF.md
# Float32 to Unsigned Integer Truncator

This block turns one IEEE-754 single-precision value into an unsigned integer. The fraction is always dropped, which rounds toward zero, whatever rounding mode the rest of the machine uses. The result is 32 bits wide by default. It is 64 bits wide only when the core runs in long mode and the width-select input is high. Besides the integer, the block returns two flags. Invalid means the value has no unsigned representation in the chosen width. Inexact means a nonzero fraction was dropped.

A mask input chooses what happens to an unrepresentable input. When the mask is set, the result saturates to the all-ones pattern of the chosen width. When the mask is clear, the result is zero and only the invalid flag signals the fault. The conversion is registered: an operand presented with `in_valid` appears on the outputs one clock later, marked by `out_valid`. The result stays on the outputs until the next operand arrives.

Top module: `fp32_to_uint_trunc`

## Requirements
- R1: While reset is asserted, and after reset until the first operand, `out_valid`, `out_value`, `out_invalid` and `out_inexact` are all zero.
- R2: A conversion is presented on the outputs exactly one clock after `in_valid` is sampled high. `out_valid` is low one clock after `in_valid` is sampled low, and back-to-back operands give back-to-back results.
- R3: A positive finite input of at least 1.0 that fits the width returns its integer part. `out_inexact` is 1 exactly when a nonzero fraction was discarded.
- R4: The width is 64 bits only when `long_mode`=1 and `wide_sel`=1. In every other case it is 32 bits and `out_value[63:32]` is zero. Outside long mode, `wide_sel` has no effect.
- R5: A positive finite input of 2^w or more, where w is the chosen width, raises `out_invalid`.
- R6: NaN (exponent field bits [30:23] all ones, fraction nonzero) and ±infinity (exponent all ones, fraction zero) raise `out_invalid`.
- R7: A negative input (bit 31 set) of magnitude 1.0 or more raises `out_invalid`. A negative input of magnitude below 1.0, including −0, returns 0 with `out_invalid`=0, and `out_inexact` set exactly when the input is nonzero.
- R8: Positive zero, denormals (exponent field 0) and values below 1.0 return 0 without invalid. `out_inexact` is set unless the input is ±0.
- R9: On invalid with `inv_mask`=1, `out_value` is 2^w−1 (upper 32 bits zero when w=32). On invalid with `inv_mask`=0, `out_value` is 0.
- R10: `out_inexact` is never set together with `out_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_word | input | 32 | Single-precision operand |
| long_mode | input | 1 | Core is in long mode; enables 64-bit results |
| wide_sel | input | 1 | Requests a 64-bit result (honoured in long mode only) |
| inv_mask | input | 1 | 1: saturate unrepresentable results to all ones; 0: return zero |
| out_valid | output | 1 | Result valid (one clock after `in_valid`) |
| out_value | output | 64 | Truncated unsigned result |
| out_invalid | output | 1 | Input not representable in the chosen width |
| out_inexact | output | 1 | A nonzero fraction was discarded |

## Verification
The bench goes after each edge of the range. It checks the largest float below 2^32 and below 2^64, where a wrong limit would wrongly flag invalid. It checks exactly 2^32 in both widths, where an off-by-one compare would let a wrapped value through. It drives negative inputs on both sides of magnitude 1.0 and −0, where a design that treats every set sign bit as invalid would flag a value that truncates to zero. Denormals and values just below one must still raise inexact. Two further cases hunt for flag and width faults. `wide_sel` is driven high outside long mode, which a design that ignores the gating would widen. Invalid inputs are applied with the mask both set and clear, which exposes inexact leaking alongside invalid and saturation of the wrong width.

// File: rtl/fp2u_pkg.sv
package fp2u_pkg;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int IN_W     = EXP_W + FRAC_W + 1;
    localparam int MANT_W   = FRAC_W + 1;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int UE_W     = EXP_W + 1;
    localparam int NARROW_W = 32;
    localparam int WIDE_W   = 64;

    // Unpacked operand fields
    typedef struct packed {
        logic                   sign;
        logic                   special;   // exponent all ones: NaN or infinity
        logic                   zero;      // +0 or -0
        logic signed [UE_W-1:0] uexp;      // unbiased exponent
        logic [MANT_W-1:0]      mant;      // significand with hidden bit
    } fp_fields_t;

    // Registered result state
    typedef struct packed {
        logic              valid;
        logic [WIDE_W-1:0] value;
        logic              invalid;
        logic              inexact;
    } conv_state_t;
endpackage

// File: rtl/fp2u_unpack.sv
module fp2u_unpack
    import fp2u_pkg::*;
(
    input  logic [IN_W-1:0] word_i,
    output fp_fields_t      fields_o
);
    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;

    always_comb begin
        exp_field        = word_i[FRAC_W +: EXP_W];
        frac_field       = word_i[FRAC_W-1:0];
        fields_o.sign    = word_i[IN_W-1];
        fields_o.special = &exp_field;
        fields_o.zero    = (exp_field == '0) && (frac_field == '0);
        fields_o.uexp    = $signed({1'b0, exp_field}) - $signed(UE_W'(BIAS));
        fields_o.mant    = {(exp_field != '0), frac_field};
    end
endmodule

// File: rtl/fp2u_align.sv
module fp2u_align
    import fp2u_pkg::*;
#(
    parameter int OUT_W = WIDE_W
) (
    input  logic [MANT_W-1:0]      mant_i,
    input  logic signed [UE_W-1:0] uexp_i,
    output logic [OUT_W-1:0]       mag_o,
    output logic                   dropped_o
);
    localparam int SH_W   = $clog2(OUT_W) + 1;
    localparam int TOP    = MANT_W - 1;
    localparam int PAD_W  = OUT_W - MANT_W;

    logic [SH_W-1:0]   lsh;
    logic [SH_W-1:0]   rsh;
    logic [MANT_W-1:0] lost_mask;

    always_comb begin
        lsh       = '0;
        rsh       = '0;
        lost_mask = '0;
        mag_o     = '0;
        dropped_o = 1'b0;
        if (uexp_i[UE_W-1]) begin
            // magnitude below one: everything is fraction
            dropped_o = |mant_i;
        end else if (uexp_i >= $signed(UE_W'(OUT_W))) begin
            // out of range; the judge flags it
            mag_o = '0;
        end else if (uexp_i >= $signed(UE_W'(TOP))) begin
            lsh   = SH_W'(uexp_i - $signed(UE_W'(TOP)));
            mag_o = {{PAD_W{1'b0}}, mant_i} << lsh;
        end else begin
            rsh       = SH_W'($signed(UE_W'(TOP)) - uexp_i);
            mag_o     = OUT_W'(mant_i >> rsh);
            lost_mask = ~({MANT_W{1'b1}} << rsh);
            dropped_o = |(mant_i & lost_mask);
        end
    end
endmodule

// File: rtl/fp2u_judge.sv
module fp2u_judge
    import fp2u_pkg::*;
(
    input  logic                   sign_i,
    input  logic                   special_i,
    input  logic                   zero_i,
    input  logic signed [UE_W-1:0] uexp_i,
    input  logic [WIDE_W-1:0]      mag_i,
    input  logic                   dropped_i,
    input  logic                   wide_i,
    input  logic                   mask_i,
    output logic [WIDE_W-1:0]      value_o,
    output logic                   invalid_o,
    output logic                   inexact_o
);
    localparam int NUM_W = 2;

    logic [NUM_W-1:0]  over;
    logic [WIDE_W-1:0] ones    [NUM_W];
    logic [WIDE_W-1:0] trimmed [NUM_W];

    // One range check and one saturation pattern per supported width
    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int W = (g == 0) ? NARROW_W : WIDE_W;
        assign over[g]    = !uexp_i[UE_W-1] && (uexp_i >= $signed(UE_W'(W)));
        assign ones[g]    = WIDE_W'({W{1'b1}});
        assign trimmed[g] = mag_i & ones[g];
    end

    logic sel;
    logic below_one;
    logic bad;

    always_comb begin
        sel       = wide_i;
        below_one = uexp_i[UE_W-1];
        bad       = special_i
                  | (!below_one && sign_i)
                  | over[sel];
        invalid_o = bad;
        if (bad) begin
            value_o   = mask_i ? ones[sel] : '0;
            inexact_o = 1'b0;
        end else if (below_one) begin
            value_o   = '0;
            inexact_o = !zero_i;
        end else begin
            value_o   = trimmed[sel];
            inexact_o = dropped_i;
        end
    end
endmodule

// File: rtl/fp32_to_uint_trunc.sv
module fp32_to_uint_trunc
    import fp2u_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    input  logic        long_mode,
    input  logic        wide_sel,
    input  logic        inv_mask,
    output logic        out_valid,
    output logic [63:0] out_value,
    output logic        out_invalid,
    output logic        out_inexact
);
    fp_fields_t        fields;
    logic [WIDE_W-1:0] mag;
    logic              dropped;
    logic              wide;
    logic [WIDE_W-1:0] conv_value;
    logic              conv_invalid;
    logic              conv_inexact;

    assign wide = long_mode & wide_sel;

    fp2u_unpack u_unpack (
        .word_i   (in_word),
        .fields_o (fields)
    );

    fp2u_align #(.OUT_W(WIDE_W)) u_align (
        .mant_i    (fields.mant),
        .uexp_i    (fields.uexp),
        .mag_o     (mag),
        .dropped_o (dropped)
    );

    fp2u_judge u_judge (
        .sign_i    (fields.sign),
        .special_i (fields.special),
        .zero_i    (fields.zero),
        .uexp_i    (fields.uexp),
        .mag_i     (mag),
        .dropped_i (dropped),
        .wide_i    (wide),
        .mask_i    (inv_mask),
        .value_o   (conv_value),
        .invalid_o (conv_invalid),
        .inexact_o (conv_inexact)
    );

    conv_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.value   = conv_value;
            st_d.invalid = conv_invalid;
            st_d.inexact = conv_inexact;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_value   = st_q.value;
    assign out_invalid = st_q.invalid;
    assign out_inexact = st_q.inexact;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> !out_inexact); // R10
    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(long_mode && wide_sel)) |=> (out_value[63:32] == 32'h0)); // R4
    AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_word[30:23])) |=> out_invalid); // R6
    AST_MASKED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inv_mask && (&in_word[30:23])) |=>
        (out_value == ($past(long_mode && wide_sel) ? 64'hFFFF_FFFF_FFFF_FFFF
                                                    : 64'h0000_0000_FFFF_FFFF))); // R9
    AST_SMALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_word[30:23] < 8'd127)) |=> (out_value == 64'h0 && !out_invalid)); // R7
endmodule

// File: tb/fp32_to_uint_trunc_tb.sv
module fp32_to_uint_trunc_tb;
    typedef struct packed {
        logic [31:0] word;
        logic        lm;
        logic        ws;
        logic        mk;
        logic [63:0] val;
        logic        inv;
        logic        inx;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{32'h3F80_0000, 1'b0, 1'b0, 1'b1, 64'h1,                   1'b0, 1'b0, 4'd3},  // R3 1.0
        '{32'h3FC0_0000, 1'b0, 1'b0, 1'b1, 64'h1,                   1'b0, 1'b1, 4'd3},  // R3 1.5
        '{32'h4030_0000, 1'b1, 1'b1, 1'b1, 64'h2,                   1'b0, 1'b1, 4'd3},  // R3 2.75
        '{32'h4AFF_FFFF, 1'b0, 1'b0, 1'b0, 64'h7F_FFFF,             1'b0, 1'b1, 4'd3},  // R3 half lost
        '{32'h4B00_0000, 1'b0, 1'b0, 1'b0, 64'h80_0000,             1'b0, 1'b0, 4'd3},  // R3 2^23
        '{32'h3F00_0000, 1'b0, 1'b0, 1'b1, 64'h0,                   1'b0, 1'b1, 4'd8},  // R8 0.5
        '{32'h0000_0000, 1'b0, 1'b0, 1'b1, 64'h0,                   1'b0, 1'b0, 4'd8},  // R8 +0
        '{32'h0000_0001, 1'b1, 1'b1, 1'b1, 64'h0,                   1'b0, 1'b1, 4'd8},  // R8 denormal
        '{32'h8000_0000, 1'b0, 1'b0, 1'b1, 64'h0,                   1'b0, 1'b0, 4'd7},  // R7 -0
        '{32'hBF00_0000, 1'b0, 1'b0, 1'b1, 64'h0,                   1'b0, 1'b1, 4'd7},  // R7 -0.5
        '{32'hBF80_0000, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF,           1'b1, 1'b0, 4'd7},  // R7 -1.0
        '{32'hBFC0_0000, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'd7},  // R7 -1.5 wide
        '{32'h7FC0_0000, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'd6},  // R6 NaN
        '{32'h7F80_0000, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF,           1'b1, 1'b0, 4'd6},  // R6 +inf, ws ignored
        '{32'hFF80_0000, 1'b1, 1'b1, 1'b0, 64'h0,                   1'b1, 1'b0, 4'd9},  // R9 -inf unmasked
        '{32'h4F7F_FFFF, 1'b0, 1'b0, 1'b1, 64'hFFFF_FF00,           1'b0, 1'b0, 4'd5},  // R5 below 2^32
        '{32'h4F80_0000, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF,           1'b1, 1'b0, 4'd5},  // R5 2^32 narrow
        '{32'h4F80_0000, 1'b0, 1'b1, 1'b0, 64'h0,                   1'b1, 1'b0, 4'd4},  // R4 ws ignored, R9 unmasked
        '{32'h4F80_0000, 1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF,           1'b1, 1'b0, 4'd4},  // R4 long mode, ws low
        '{32'h4F80_0000, 1'b1, 1'b1, 1'b1, 64'h1_0000_0000,         1'b0, 1'b0, 4'd4},  // R4 wide result
        '{32'h5F7F_FFFF, 1'b1, 1'b1, 1'b1, 64'hFFFF_FF00_0000_0000, 1'b0, 1'b0, 4'd5},  // R5 below 2^64
        '{32'h5F80_0000, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'd5}   // R5 2^64, R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        long_mode = 1'b0;
    logic        wide_sel = 1'b0;
    logic        inv_mask = 1'b0;
    logic        out_valid;
    logic [63:0] out_value;
    logic        out_invalid;
    logic        out_inexact;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fp32_to_uint_trunc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .long_mode   (long_mode),
        .wide_sel    (wide_sel),
        .inv_mask    (inv_mask),
        .out_valid   (out_valid),
        .out_value   (out_value),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [63:0] val,
                             input logic inv, input logic inx);
        check(req, "out_valid", 64'(out_valid), 64'h1);
        check(req, "out_value", out_value, val);
        check(req, "out_invalid", 64'(out_invalid), 64'(inv));
        check(req, "out_inexact", 64'(out_inexact), 64'(inx));
    endtask

    task automatic drive(input vec_t v);
        in_valid  = 1'b1;
        in_word   = v.word;
        long_mode = v.lm;
        wide_sel  = v.ws;
        inv_mask  = v.mk;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", 64'(out_valid), 64'h0);
        check("R1", "out_value in reset", out_value, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after reset", {62'h0, out_invalid, out_inexact}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                      VECS[i].val, VECS[i].inv, VECS[i].inx);
        end

        // R2: idle cycle drops out_valid
        @(negedge clk);
        check("R2", "out_valid idle", 64'(out_valid), 64'h0);

        // R2: back-to-back operands
        @(negedge clk);
        drive(VECS[1]);
        @(negedge clk);
        check_all("R2 b2b first", 64'h1, 1'b0, 1'b1);
        drive(VECS[19]);
        @(negedge clk);
        in_valid = 1'b0;
        check_all("R2 b2b second", 64'h1_0000_0000, 1'b0, 1'b0);
        @(negedge clk);
        check("R2", "out_valid after burst", 64'(out_valid), 64'h0);

        // R1: reset mid-run clears the held result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "value after second reset", out_value, 64'h0);
        check("R1", "valid after second reset", 64'(out_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule